// File: doc/BRIEF.md
# Coefficient Block Burst Port

This block holds the filter coefficients of every channel: 40 words of 14 bits per channel, grouped into five blocks of eight words. A host reaches it through a byte-serial port framed by an active-low chip select. A deserialiser ahead of this block turns the serial stream into byte strobes. The first byte of each frame is a command byte. A RAM command names one block, and the block then moves all eight of its words in a single burst, with no further commands. The burst starts at the highest word index of the block and counts down.

Each word travels as two bytes, most significant bit first, filled out to 16 bits with two padding bits at the bottom. On a write, the padding bits are dropped, and each completed word is stored in every channel enabled by the channel-enable input. On a read, the word comes from the lowest-numbered enabled channel, and the padding bits are sent as zero. If chip select rises partway through a burst, the rest of the burst is abandoned. Words already completed keep their new values.

Top module: `coe_burst_port`

## Requirements
- R1: After reset every stored word in every channel is zero and `out_vld` is low.
- R2: The command byte holds a read flag in bit 7, a type in bits 6:5 and a block number in bits 4:0. The RAM type code is 2'b10. Block b covers words 8b to 8b+7. A write burst stores its first byte pair at word 8b+7, then 8b+6, and so on down to 8b.
- R3: A written word is the 16-bit pair with its two lowest bits dropped: stored = {first byte, second byte[7:2]}.
- R4: A read sends each word as a first byte equal to word[13:6] and a second byte equal to {word[5:0], 2'b00}. The output byte is valid (`out_vld` high) in the cycle after the byte strobe it answers. Words follow the same descending order as writes.
- R5: A write updates the addressed word in every channel whose `chan_en` bit is set. Channels whose bit is clear keep their contents.
- R6: A read takes its data from the lowest-numbered enabled channel.
- R7: When chip select goes high, the burst ends. A word whose second byte has not arrived is not stored. Words completed earlier stay stored.
- R8: A RAM command whose block number is 5 to 31 is ignored. It writes nothing and produces no output bytes.
- R9: A command byte whose type is not the RAM code is ignored for the rest of the frame.
- R10: After eight words, any further bytes in the same frame are ignored. They cause no write and no output.
- R11: The first strobed byte after chip select falls is always taken as a command and produces no output byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| byte_stb | input | 1 | One-cycle strobe marking a byte slot |
| byte_in | input | 8 | Incoming byte (command or write data) |
| chan_en | input | NCH | Channel enable mask |
| out_vld | output | 1 | Read byte valid |
| out_byte | output | 8 | Read byte |

## Verification
The bench builds the block with its default parameters: eight channels, five blocks of eight words, and 14-bit words. With these values the two padding bits are real, so writes can carry nonzero junk in them. Several channel masks can be tried against one another, and block numbers 5 to 31 in the 5-bit address field test the range check. A reference model of all 320 words predicts every read byte. A scoreboard matches each predicted byte against the output, so writes, aborts and ignored commands are all judged through later reads.

// File: rtl/coe_pkg.sv
package coe_pkg;
    localparam logic [1:0] KIND_RAM = 2'b10;

    typedef struct packed {
        logic       rd;
        logic [1:0] kind;
        logic [4:0] addr;
    } cmd_t;

    typedef enum logic [1:0] {
        ST_CMD  = 2'd0,
        ST_WR   = 2'd1,
        ST_RD   = 2'd2,
        ST_SKIP = 2'd3
    } st_t;
endpackage

// File: rtl/coe_frame_ctrl.sv
module coe_frame_ctrl
    import coe_pkg::*;
#(
    parameter int NBLK = 5,
    parameter int WPB  = 8,
    parameter int WW   = 14,
    localparam int NWORD = NBLK * WPB,
    localparam int AW    = $clog2(NWORD),
    localparam int CW    = $clog2(WPB + 1),
    localparam int PAD   = 16 - WW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          byte_stb,
    input  logic [7:0]    byte_in,
    input  logic [WW-1:0] rd_word,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [WW-1:0] wdata,
    output logic [AW-1:0] raddr,
    output logic          out_vld,
    output logic [7:0]    out_byte
);
    typedef struct packed {
        st_t           st;
        logic [AW-1:0] idx;
        logic [CW-1:0] wleft;
        logic          phase;
        logic [7:0]    hold;
        logic          out_vld;
        logic [7:0]    out_byte;
    } ctl_t;

    ctl_t s_d, s_q;
    cmd_t cmd;
    logic take;

    assign cmd  = cmd_t'(byte_in);
    assign take = byte_stb && !cs_n;

    always_comb begin
        s_d         = s_q;
        s_d.out_vld = 1'b0;
        we          = 1'b0;
        waddr       = s_q.idx;
        wdata       = {s_q.hold, byte_in[7:PAD]};
        if (cs_n) begin
            s_d.st    = ST_CMD;
            s_d.phase = 1'b0;
        end else if (take) begin
            case (s_q.st)
                ST_CMD: begin
                    s_d.phase = 1'b0;
                    s_d.wleft = CW'(WPB);
                    s_d.idx   = AW'(cmd.addr) * AW'(WPB) + AW'(WPB - 1);
                    if (cmd.kind == KIND_RAM && int'(cmd.addr) < NBLK)
                        s_d.st = cmd.rd ? ST_RD : ST_WR;
                    else
                        s_d.st = ST_SKIP;
                end
                ST_WR: begin
                    if (!s_q.phase) begin
                        s_d.hold  = byte_in;
                        s_d.phase = 1'b1;
                    end else begin
                        we        = 1'b1;
                        s_d.phase = 1'b0;
                        s_d.idx   = s_q.idx - 1'b1;
                        s_d.wleft = s_q.wleft - 1'b1;
                        if (s_q.wleft == CW'(1)) s_d.st = ST_SKIP;
                    end
                end
                ST_RD: begin
                    s_d.out_vld = 1'b1;
                    if (!s_q.phase) begin
                        s_d.out_byte = rd_word[WW-1:WW-8];
                        s_d.phase    = 1'b1;
                    end else begin
                        s_d.out_byte = {rd_word[WW-9:0], {PAD{1'b0}}};
                        s_d.phase    = 1'b0;
                        s_d.idx      = s_q.idx - 1'b1;
                        s_d.wleft    = s_q.wleft - 1'b1;
                        if (s_q.wleft == CW'(1)) s_d.st = ST_SKIP;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_CMD, idx: '0, wleft: '0, phase: 1'b0,
                     hold: '0, out_vld: 1'b0, out_byte: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign raddr    = s_q.idx;
    assign out_vld  = s_q.out_vld;
    assign out_byte = s_q.out_byte;

    AST_WE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (byte_stb && !cs_n)); // R7
    AST_WADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(waddr) < NWORD)); // R8
    AST_OUT_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(byte_stb && !cs_n)); // R4
    AST_CMD_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (take && s_q.st == ST_CMD) |=> !out_vld); // R11
    AST_LO_PADDED: assert property (@(posedge clk) disable iff (!rst_n)
        (take && s_q.st == ST_RD && s_q.phase) |=> (out_byte[PAD-1:0] == '0)); // R4
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_SKIP) |=> !out_vld && !we); // R10
endmodule

// File: rtl/coe_store.sv
module coe_store #(
    parameter int NCH  = 8,
    parameter int NBLK = 5,
    parameter int WPB  = 8,
    parameter int WW   = 14,
    localparam int NWORD = NBLK * WPB,
    localparam int AW    = $clog2(NWORD),
    localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] chan_en,
    input  logic           we,
    input  logic [AW-1:0]  waddr,
    input  logic [WW-1:0]  wdata,
    input  logic [AW-1:0]  raddr,
    output logic [WW-1:0]  rd_word
);
    logic [WW-1:0] mem_q [NCH][NWORD];
    logic [CHW-1:0] rd_ch;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int w = 0; w < NWORD; w++) mem_q[c][w] <= '0;
            end else if (we && chan_en[c]) begin
                mem_q[c][waddr] <= wdata;
            end
        end
    end

    always_comb begin
        rd_ch = '0;
        for (int c = NCH - 1; c >= 0; c--)
            if (chan_en[c]) rd_ch = CHW'(c);
    end

    assign rd_word = ((|chan_en) && int'(raddr) < NWORD) ? mem_q[rd_ch][raddr] : '0;

    always_comb begin
        if (rst_n && we) begin
            AST_STORE_ADDR: assert (int'(waddr) < NWORD); // R2
        end
    end
endmodule

// File: rtl/coe_burst_port.sv
module coe_burst_port #(
    parameter int NCH  = 8,
    parameter int NBLK = 5,
    parameter int WPB  = 8,
    parameter int WW   = 14,
    localparam int NWORD = NBLK * WPB,
    localparam int AW    = $clog2(NWORD)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n,
    input  logic           byte_stb,
    input  logic [7:0]     byte_in,
    input  logic [NCH-1:0] chan_en,
    output logic           out_vld,
    output logic [7:0]     out_byte
);
    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [WW-1:0] wdata;
    logic [WW-1:0] rd_word;

    coe_frame_ctrl #(.NBLK(NBLK), .WPB(WPB), .WW(WW)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_stb(byte_stb),
        .byte_in(byte_in), .rd_word(rd_word), .we(we), .waddr(waddr),
        .wdata(wdata), .raddr(raddr), .out_vld(out_vld), .out_byte(out_byte)
    );

    coe_store #(.NCH(NCH), .NBLK(NBLK), .WPB(WPB), .WW(WW)) store_i (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .we(we),
        .waddr(waddr), .wdata(wdata), .raddr(raddr), .rd_word(rd_word)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_vld); // R1
endmodule

// File: tb/coe_burst_port_tb.sv
module coe_burst_port_tb_top;
    localparam int NCH = 8;
    localparam int NWORD = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic byte_stb = 1'b0;
    logic [7:0] byte_in = '0;
    logic [NCH-1:0] chan_en = '0;
    logic out_vld;
    logic [7:0] out_byte;

    int checks = 0;
    int errors = 0;
    logic [13:0] model [NCH][NWORD];
    logic [7:0] exp_q [$];
    string tag_q [$];

    always #5 clk = ~clk;

    coe_burst_port dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_stb(byte_stb),
        .byte_in(byte_in), .chan_en(chan_en), .out_vld(out_vld), .out_byte(out_byte)
    );

    // monitor: pops expected bytes as the design emits them
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected byte (R8/R9/R10): actual %02h expected none", out_byte);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (out_byte !== e) begin
                    errors++;
                    $display("FAIL %s: actual %02h expected %02h", t, out_byte, e);
                end
            end
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        byte_stb = 1'b1;
        byte_in  = b;
        @(negedge clk);
        byte_stb = 1'b0;
    endtask

    task automatic open_frame(input logic [NCH-1:0] en);
        @(negedge clk);
        chan_en = en;
        cs_n = 1'b0;
    endtask

    task automatic close_frame();
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic int low_ch(input logic [NCH-1:0] en);
        for (int c = NCH - 1; c >= 0; c--) if (en[c]) low_ch = c;
        if (en == '0) low_ch = -1;
    endfunction

    // write nwords full words (plus optional lone first byte) of block blk
    task automatic wr_block(input logic [NCH-1:0] en, input int blk, input int seed,
                            input int nwords, input bit half);
        open_frame(en);
        send({1'b0, 2'b10, 5'(blk)});
        for (int k = 0; k < nwords; k++) begin
            logic [13:0] w;
            w = 14'((seed * 37 + k * 1013 + 5) & 16'h3fff);
            send(w[13:6]);
            send({w[5:0], 2'(k + 1)});  // junk in padding bits, R3
            for (int c = 0; c < NCH; c++)
                if (en[c] && blk < 5) model[c][blk * 8 + 7 - k] = w;
        end
        if (half) send(8'hA5);
        close_frame();
    endtask

    task automatic rd_block(input logic [NCH-1:0] en, input int blk, input string tag,
                            input int extra);
        int ch;
        ch = low_ch(en);
        open_frame(en);
        send({1'b1, 2'b10, 5'(blk)});
        for (int k = 0; k < 8; k++) begin
            logic [13:0] w;
            w = (ch < 0) ? 14'h0 : model[ch][blk * 8 + 7 - k];
            exp_q.push_back(w[13:6]);      tag_q.push_back(tag);
            send(8'h00);
            exp_q.push_back({w[5:0], 2'b00}); tag_q.push_back(tag);
            send(8'h00);
        end
        for (int x = 0; x < extra; x++) send(8'h00);
        close_frame();
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: actual %0d bytes missing expected 0", tag, exp_q.size());
            exp_q.delete(); tag_q.delete();
        end
    endtask

    task automatic expect_silent(input logic [7:0] cmd, input string tag);
        open_frame(8'h01);
        send(cmd);
        for (int k = 0; k < 6; k++) send(8'h3C);
        close_frame();
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++)
            for (int w = 0; w < NWORD; w++) model[c][w] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_vld !== 1'b0) begin
            errors++;
            $display("FAIL R1: out_vld actual %b expected 0", out_vld);
        end
        rd_block(8'h01, 4, "R1 reset zero", 0);
        rd_block(8'h80, 0, "R1 reset zero ch7", 0);

        // R2 R3 R4: full write then read, each block
        for (int b = 0; b < 5; b++) wr_block(8'h01, b, b + 11, 8, 0);
        for (int b = 0; b < 5; b++) rd_block(8'h01, b, "R2 R3 R4 block order", 0);

        // R5: multi-channel write, disabled channel keeps old value
        wr_block(8'b0010_0100, 3, 77, 8, 0);
        rd_block(8'b0000_0100, 3, "R5 enabled ch2", 0);
        rd_block(8'b0010_0000, 3, "R5 enabled ch5", 0);
        rd_block(8'b0000_1000, 3, "R5 disabled ch3 unchanged", 0);
        rd_block(8'b0000_0001, 3, "R5 disabled ch0 unchanged", 0);

        // R6: read picks lowest enabled channel
        rd_block(8'b1010_0100, 3, "R6 lowest enabled", 0);
        rd_block(8'b0110_0001, 3, "R6 lowest enabled ch0", 0);

        // R7: abort after 3 words plus a half word
        wr_block(8'h02, 1, 200, 3, 1);
        rd_block(8'h02, 1, "R7 abort keeps completed", 0);
        // R7 read abort followed by a fresh frame
        open_frame(8'h01);
        send({1'b1, 2'b10, 5'd0});
        exp_q.push_back(model[0][7][13:6]); tag_q.push_back("R7 read abort");
        send(8'h00);
        close_frame();
        rd_block(8'h01, 0, "R7 R11 new frame after abort", 0);

        // R8: out of range blocks
        expect_silent({1'b0, 2'b10, 5'd5}, "R8");
        expect_silent({1'b0, 2'b10, 5'd31}, "R8");
        expect_silent({1'b1, 2'b10, 5'd7}, "R8");
        // R9: other command types
        expect_silent({1'b1, 2'b01, 5'd1}, "R9");
        expect_silent({1'b0, 2'b00, 5'd2}, "R9");
        rd_block(8'h01, 2, "R8 R9 memory untouched", 0);

        // R10: extra bytes after a full burst
        open_frame(8'h01);
        send({1'b0, 2'b10, 5'd4});
        for (int k = 0; k < 8; k++) begin
            send(8'h12); send(8'h34);
            model[0][39 - k] = {8'h12, 6'h0d};
        end
        send(8'hFF); send(8'hFF); send(8'hFF); send(8'hFF);
        close_frame();
        rd_block(8'h01, 4, "R10 extra write bytes ignored", 0);
        rd_block(8'h01, 4, "R10 extra read strobes silent", 4);
        rd_block(8'h01, 3, "R10 neighbour block intact", 0);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule